// File: doc/BRIEF.md
# Decimal-Addressed Program Step Store

This block is a plug-in program memory for a keystroke calculator. It holds 5,000 program steps, addressed 0000 to 4999. Each step is 8 bits wide and holds two BCD digits. A host reaches it through a 4-bit, digit-at-a-time bus and a two-bit command code with a strobe. Internally the block keeps a four-digit BCD address pointer.

The host can write the pointer one digit per clock, or read it back the same way. It can fetch a whole step, low digit first, after which the pointer advances by one in decimal. It can also peek at only the upper digit of a step, and the pointer stays where it is. The step contents are a fixed arithmetic function of the address digits, so the block needs no storage array. A sticky flag records every fetch or peek at an address outside the populated range. A second sticky flag records every malformed pointer digit.

Top module: `bcd_step_rom`

## Requirements
- R1: After reset, the pointer is 0000, `busy`, `dout_valid`, `range_err` and `digit_err` are 0, and the block accepts a command on the next strobe.
- R2: Command code 0 (pointer write) takes the four digits presented on `din` in the four clocks after the strobe, least significant digit first, and installs them as the pointer.
- R3: A pointer-write digit above 9 sets the sticky `digit_err`, and the pointer keeps its previous value even if the other digits were legal.
- R4: Command code 1 (step fetch) emits two digits, the low digit first and then the high digit. With address digits d0 (least significant) to d3, low = (d0 + 3·d1 + 5·d2 + 7·d3) mod 10 and high = (2·d0 + 3·d1 + 4·d2 + 5·d3 + 5) mod 10.
- R5: A step fetch advances the pointer by one in decimal after its second digit. A digit at 9 becomes 0 and carries into the next digit, and 9999 becomes 0000.
- R6: Command code 2 (upper peek) emits only the high digit of the addressed step and leaves the pointer unchanged.
- R7: Command code 3 (pointer read) emits the four pointer digits, least significant first, and leaves the pointer unchanged.
- R8: A fetch or peek at an address whose most significant digit is above 4 emits 0xF in place of each step digit and sets the sticky `range_err`. A fetch there still advances the pointer.
- R9: `busy` is high from the clock after an accepted strobe until the transfer ends. A strobe that arrives while `busy` is high is ignored.
- R10: Each output digit is valid for exactly one clock. The first digit appears two clocks after the strobe edge, and the remaining digits follow on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code: 0 pointer write, 1 step fetch, 2 upper peek, 3 pointer read |
| din | input | 4 | Pointer digit input for a pointer write |
| dout | output | 4 | Output digit |
| dout_valid | output | 1 | High for one clock per output digit |
| busy | output | 1 | A transfer is in progress |
| range_err | output | 1 | Sticky: an access touched an address above 4999 |
| digit_err | output | 1 | Sticky: a pointer write carried a non-decimal digit |

## Verification
The bench walks the pointer across each decimal carry position (0099 to 0100) and across the top wrap from 9999 to 0000. A design that used a binary increment there would read back hex digits. It fetches at 4999 and then at 5000. This catches a range test that is off by one, or one that fails to substitute 0xF. It loads a pointer with one bad digit in the middle. A design that commits the legal digits, or forgets the flag, shows the wrong pointer on read-back. It also fires a second strobe into a running fetch. A design that accepts it emits extra digits, and the scoreboard reports those as unexpected.

// File: rtl/bcd_step_rom.sv
module bcd_step_rom #(
  parameter int DIGITS  = 4,
  parameter int MAX_MSD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [3:0] din,
  output logic [3:0] dout,
  output logic       dout_valid,
  output logic       busy,
  output logic       range_err,
  output logic       digit_err
);
  localparam int PW = DIGITS * 4;
  localparam int CW = $clog2(DIGITS) + 1;
  localparam logic [PW-1:0] ALL_NINES = {DIGITS{4'h9}};

  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_FETCH = 2'd1, OP_PEEK = 2'd2, OP_UNLOAD = 2'd3} op_t;
  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SEND} st_t;

  st_t           st;
  op_t           op;
  logic [CW-1:0] cnt, last_cnt;
  logic [PW-1:0] ptr, shadow, load_val;
  logic          bad;
  logic [3:0]    lo, hi, send_digit;
  logic          oor;

  function automatic logic [PW-1:0] bcd_inc(input logic [PW-1:0] v);
    logic [PW-1:0] r;
    logic          c;
    r = v;
    c = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (c) begin
        if (r[i*4 +: 4] == 4'd9) r[i*4 +: 4] = 4'd0;
        else begin
          r[i*4 +: 4] = r[i*4 +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    return r;
  endfunction

  always_comb begin
    int slo, shi;
    slo = 0;
    shi = 5;
    for (int i = 0; i < DIGITS; i++) begin
      slo = slo + (2 * i + 1) * int'(ptr[i*4 +: 4]);
      shi = shi + (i + 2) * int'(ptr[i*4 +: 4]);
    end
    lo = 4'(slo % 10);
    hi = 4'(shi % 10);
  end

  assign oor  = ptr[PW-1 -: 4] > 4'(MAX_MSD);
  assign busy = (st != S_IDLE);

  always_comb begin
    load_val = shadow;
    load_val[PW-1 -: 4] = din;
  end

  always_comb begin
    case (op)
      OP_FETCH: last_cnt = CW'(1);
      OP_PEEK:  last_cnt = CW'(0);
      default:  last_cnt = CW'(DIGITS - 1);
    endcase
  end

  always_comb begin
    case (op)
      OP_FETCH: send_digit = oor ? 4'hF : (cnt == '0 ? lo : hi);
      OP_PEEK:  send_digit = oor ? 4'hF : hi;
      default:  send_digit = ptr[{cnt, 2'b00} +: 4];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      op         <= OP_LOAD;
      cnt        <= '0;
      ptr        <= '0;
      shadow     <= '0;
      bad        <= 1'b0;
      dout       <= '0;
      dout_valid <= 1'b0;
      range_err  <= 1'b0;
      digit_err  <= 1'b0;
    end else begin
      dout_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op  <= op_t'(cmd_op);
          cnt <= '0;
          bad <= 1'b0;
          st  <= (op_t'(cmd_op) == OP_LOAD) ? S_LOAD : S_SEND;
        end
        S_LOAD: begin
          if (din > 4'd9) digit_err <= 1'b1;
          shadow[{cnt, 2'b00} +: 4] <= din;
          if (cnt == CW'(DIGITS - 1)) begin
            st <= S_IDLE;
            if (!bad && din <= 4'd9) ptr <= load_val;
          end else begin
            cnt <= cnt + 1'b1;
            bad <= bad | (din > 4'd9);
          end
        end
        S_SEND: begin
          dout       <= send_digit;
          dout_valid <= 1'b1;
          if (op != OP_UNLOAD && oor) range_err <= 1'b1;
          if (cnt == last_cnt) begin
            st <= S_IDLE;
            if (op == OP_FETCH) ptr <= bcd_inc(ptr);
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_busy_after_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> busy);
  p_op_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && cnt != last_cnt) |=> $stable(op));
  p_first_digit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && cmd_op != 2'd0) |=> ##1 dout_valid);
  p_digit_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (dout <= 4'd9 || dout == 4'hF));
  p_range_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |=> range_err);
  p_digit_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    digit_err |=> digit_err);
  p_load_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && cnt == CW'(DIGITS - 1) && (bad || din > 4'd9)) |=> $stable(ptr));
  p_peek_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && op == OP_PEEK) |=> $stable(ptr));
  p_unload_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && op == OP_UNLOAD) |=> $stable(ptr));
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && op == OP_FETCH && cnt == CW'(1) && ptr == ALL_NINES) |=> ptr == '0);
endmodule

// File: tb/tb_bcd_step_rom.sv
`timescale 1ns/1ps
module tb_bcd_step_rom;
  logic       clk = 0, rst_n = 0, cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [3:0] din = 0;
  logic [3:0] dout;
  logic       dout_valid, busy, range_err, digit_err;

  bcd_step_rom dut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .din(din),
                    .dout(dout), .dout_valid(dout_valid), .busy(busy),
                    .range_err(range_err), .digit_err(digit_err));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int mp[4];
  logic [3:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int s_lo();
    return (mp[0] + 3*mp[1] + 5*mp[2] + 7*mp[3]) % 10;
  endfunction
  function automatic int s_hi();
    return (2*mp[0] + 3*mp[1] + 4*mp[2] + 5*mp[3] + 5) % 10;
  endfunction

  always @(negedge clk) if (rst_n && dout_valid) begin
    if (exp_q.size() == 0) chk(0, "R9 unexpected digit", int'(dout), -1);
    else begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(dout == e, t, int'(dout), int'(e));
    end
  end

  task automatic push(input int d, input string t);
    exp_q.push_back(4'(d));
    tag_q.push_back(t);
  endtask

  task automatic issue(input int op);
    @(negedge clk);
    cmd_valid = 1;
    cmd_op = 2'(op);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic finish_xfer();
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R10 digits outstanding", exp_q.size(), 0);
  endtask

  task automatic do_load(input int d0, input int d1, input int d2, input int d3);
    int v[4];
    bit ok;
    v = '{d0, d1, d2, d3};
    @(negedge clk);
    cmd_valid = 1;
    cmd_op = 2'd0;
    ok = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cmd_valid = 0;
      din = 4'(v[i]);
      if (v[i] > 9) ok = 0;
    end
    @(negedge clk);
    chk(!busy, "R2 busy after load", busy, 0);
    if (ok) mp = v;
  endtask

  task automatic do_unload(input string t);
    for (int i = 0; i < 4; i++) push(mp[i], t);
    issue(3);
    finish_xfer();
  endtask

  task automatic model_inc();
    for (int i = 0; i < 4; i++) begin
      if (mp[i] == 9) mp[i] = 0;
      else begin
        mp[i]++;
        break;
      end
    end
  endtask

  task automatic do_fetch(input string t);
    if (mp[3] > 4) begin
      push(15, {t, " R8 low"});
      push(15, {t, " R8 high"});
    end else begin
      push(s_lo(), {t, " R4 low"});
      push(s_hi(), {t, " R4 high"});
    end
    issue(1);
    finish_xfer();
    model_inc();
  endtask

  task automatic do_peek(input string t);
    push(mp[3] > 4 ? 15 : s_hi(), t);
    issue(2);
    finish_xfer();
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog expired", 0, 1);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end

  initial begin
    mp = '{0, 0, 0, 0};
    repeat (3) @(negedge clk);
    chk(!busy && !dout_valid, "R1 idle outputs", {busy, dout_valid}, 0);
    chk(!range_err && !digit_err, "R1 flags clear", {range_err, digit_err}, 0);
    rst_n = 1;
    @(negedge clk);
    do_unload("R1 reset pointer");

    do_fetch("fetch@0000");
    do_unload("R5 after fetch");

    do_load(4, 3, 2, 1);
    do_unload("R2 load 1234");
    do_fetch("fetch@1234");
    do_peek("R6 peek@1235");
    do_peek("R6 peek again");
    do_unload("R6 R7 pointer held");

    do_load(9, 9, 0, 0);
    do_fetch("fetch@0099");
    do_unload("R5 carry to 0100");

    do_load(9, 9, 9, 4);
    chk(!range_err, "R8 no flag before", range_err, 0);
    do_fetch("fetch@4999");
    chk(!range_err, "R8 4999 in range", range_err, 0);
    do_unload("R5 to 5000");
    do_fetch("fetch@5000");
    chk(range_err, "R8 flag set", range_err, 1);
    do_peek("R8 peek@5001");

    do_load(9, 9, 9, 9);
    do_fetch("fetch@9999");
    do_unload("R5 wrap to 0000");

    do_load(2, 0, 0, 3);
    chk(!digit_err, "R3 flag clear before", digit_err, 0);
    do_load(7, 10, 1, 2);
    chk(digit_err, "R3 flag set", digit_err, 1);
    do_unload("R3 pointer kept");
    do_load(5, 0, 0, 14);
    do_unload("R3 bad last digit");
    chk(range_err && digit_err, "R3 R8 sticky", {range_err, digit_err}, 3);

    push(s_lo(), "R10 low");
    push(s_hi(), "R10 high");
    issue(1);
    chk(busy, "R9 busy", busy, 1);
    cmd_valid = 1;
    cmd_op = 2'd3;
    @(negedge clk);
    chk(dout_valid, "R10 first digit timing", dout_valid, 1);
    cmd_valid = 0;
    @(negedge clk);
    chk(dout_valid, "R10 second digit consecutive", dout_valid, 1);
    @(negedge clk);
    chk(!dout_valid, "R10 single-clock valid", dout_valid, 0);
    chk(!busy, "R9 strobe ignored", busy, 0);
    model_inc();
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R9 nothing extra", exp_q.size(), 0);
    do_unload("R9 pointer after ignore");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
    end
    $finish;
  end
endmodule